// File: doc/BRIEF.md
# Instruction Pointer Sequencer

This unit owns the 16-bit instruction pointer of a small 8-bit processor whose instructions are a fixed 16 bits wide: an 8-bit opcode in the upper byte and an 8-bit argument byte in the lower byte. The fetch logic presents the current instruction word. Elsewhere in the core, an instruction-done strobe marks the end of each instruction. At that point the unit moves the pointer to the next instruction.

The normal move is +2. A conditional jump loads the address-pointer value less 2, and the normal +2 is then applied. A conditional skip adds a signed offset, and the normal +2 is then applied. The offset is the argument plus one when the argument is 0..127. For 128..255 the offset is the argument minus 256. In both cases the offset is then doubled. The unit also recognises the halt and no-operation opcodes. It rejects an instruction that sets argument bits its opcode does not use. It accepts a violation request from other logic. Any of these halts the unit and records a distinct exit code.

The outputs are registered and change one clock after the strobe or request that causes them. After a halt, the unit stays frozen until the next reset.

Top module: `insn_ptr_seq`

## Requirements
- R1: In the cycle after reset is released, ip_o is 0x0002, running_o is 1, exit_code_o is 0x00 and malformed_o is 0.
- R2: While running and with neither done_i nor viol_i high, ip_o keeps its value.
- R3: On done_i with opcode 0x00 and argument 0x00, or with any opcode other than 0x00, 0xE0..0xE3 and 0xFF, ip_o advances by 2 modulo 2^16 (0xFFFE advances to 0x0000).
- R4: Opcode 0xE0 (jump when the test flag is 1) and opcode 0xE1 (jump when the test flag is 0) both need argument 0x00. When taken, ip_o becomes ap_i. When not taken, ip_o advances by 2.
- R5: Opcode 0xE2 (skip when the test flag is 1) and opcode 0xE3 (skip when the test flag is 0) take an 8-bit argument n. When taken, ip_o becomes ip_o + 2 + 2·(n+1) for n ≤ 127, or ip_o + 2 + 2·(n−256) for n ≥ 128, modulo 2^16. When not taken, ip_o advances by 2.
- R6: On done_i with instruction word 0xFF00, running_o falls, exit_code_o becomes 0x00 and ip_o keeps the halting instruction's address.
- R7: On done_i with opcode 0x00, 0xFF, 0xE0 or 0xE1 and a nonzero argument byte, running_o falls, malformed_o becomes 1, exit_code_o becomes 0x01 and ip_o keeps its value.
- R8: viol_i high while running halts the unit with exit_code_o 0x02 and ip_o unchanged. This takes precedence over done_i in the same cycle, whatever the instruction.
- R9: While halted, done_i and viol_i have no effect: all outputs hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 16 | Current instruction word (opcode in bits 15:8, argument in bits 7:0) |
| tflag_i | input | 1 | Test flag from the flag register |
| ap_i | input | 16 | Address-pointer register value, used as the jump target |
| done_i | input | 1 | Current instruction has finished |
| viol_i | input | 1 | Access-violation halt request |
| ip_o | output | 16 | Instruction pointer |
| running_o | output | 1 | 1 while executing, 0 once halted |
| malformed_o | output | 1 | Halt was caused by a malformed instruction |
| exit_code_o | output | 8 | Exit code recorded at halt |

## Verification
Two functions can coincide in one cycle: a violation request and the retirement of an instruction. The retiring instruction may be a jump, a skip, a halt or a malformed word. The bench forces this directly by raising viol_i together with done_i on a halt word. The random phase also raises viol_i in cycles where done_i retires an arbitrary instruction. Each such cycle passes only if the pointer stays put and the exit code is 0x02, not the code or target the instruction alone would have produced.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  localparam int OPC_W = 8;
  localparam int ARG_W = 8;
  localparam int EXC_W = 8;

  localparam logic [OPC_W-1:0] OPC_NOP    = 8'h00;
  localparam logic [OPC_W-1:0] OPC_HALT   = 8'hFF;
  localparam logic [OPC_W-1:0] OPC_JMP_T  = 8'hE0;
  localparam logic [OPC_W-1:0] OPC_JMP_NT = 8'hE1;
  localparam logic [OPC_W-1:0] OPC_SKP_T  = 8'hE2;
  localparam logic [OPC_W-1:0] OPC_SKP_NT = 8'hE3;

  localparam logic [EXC_W-1:0] EXC_END  = 8'h00;
  localparam logic [EXC_W-1:0] EXC_MALF = 8'h01;
  localparam logic [EXC_W-1:0] EXC_VIOL = 8'h02;

  typedef enum logic [1:0] {ACT_STEP, ACT_JUMP, ACT_SKIP, ACT_HALT} act_e;

  // Argument bits each opcode may use; all others must be zero.
  function automatic logic [ARG_W-1:0] legal_args(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_NOP, OPC_HALT, OPC_JMP_T, OPC_JMP_NT: legal_args = '0;
      default:                                  legal_args = '1;
    endcase
  endfunction
endpackage

// File: rtl/ipu_decode.sv
module ipu_decode
  import ipu_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [ARG_W-1:0] arg,
  input  logic             tflag,
  output act_e             act,
  output logic             take,
  output logic             bad
);
  always_comb begin
    act  = ACT_STEP;
    take = 1'b0;
    case (opc)
      OPC_HALT:   act = ACT_HALT;
      OPC_JMP_T:  begin act = ACT_JUMP; take = tflag;  end
      OPC_JMP_NT: begin act = ACT_JUMP; take = !tflag; end
      OPC_SKP_T:  begin act = ACT_SKIP; take = tflag;  end
      OPC_SKP_NT: begin act = ACT_SKIP; take = !tflag; end
      default:    act = ACT_STEP;
    endcase
    bad = |(arg & ~legal_args(opc));
  end
endmodule

// File: rtl/ipu_target.sv
module ipu_target
  import ipu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP   = 2
) (
  input  logic [ADDR_W-1:0] ip,
  input  logic [ADDR_W-1:0] ap,
  input  logic [ARG_W-1:0]  arg,
  input  act_e              act,
  input  logic              take,
  output logic [ADDR_W-1:0] next_ip
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] arg_sx;
  logic [ADDR_W-1:0] bias;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base;

  generate
    if (ADDR_W > ARG_W) begin : g_ext
      assign arg_sx = {{(ADDR_W-ARG_W){arg[ARG_W-1]}}, arg};
    end else begin : g_trunc
      assign arg_sx = arg[ADDR_W-1:0];
    end
  endgenerate

  // Forward distances are biased by one slot; backward ones are not.
  assign bias   = arg[ARG_W-1] ? arg_sx : arg_sx + 1'b1;
  assign offset = bias + bias;

  always_comb begin
    base = ip;
    if (take && act == ACT_JUMP) base = ap - STEP_V;
    if (take && act == ACT_SKIP) base = ip + offset;
    next_ip = base + STEP_V;
  end
endmodule

// File: rtl/ipu_state.sv
module ipu_state
  import ipu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RESET_IP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              viol,
  input  act_e              act,
  input  logic              bad,
  input  logic [ADDR_W-1:0] next_ip,
  output logic [ADDR_W-1:0] ip_q,
  output logic              run_q,
  output logic              malf_q,
  output logic [EXC_W-1:0]  exc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q   <= ADDR_W'(RESET_IP);
      run_q  <= 1'b1;
      malf_q <= 1'b0;
      exc_q  <= '0;
    end else if (run_q) begin
      if (viol) begin
        run_q <= 1'b0;
        exc_q <= EXC_VIOL;
      end else if (done) begin
        if (bad) begin
          run_q  <= 1'b0;
          malf_q <= 1'b1;
          exc_q  <= EXC_MALF;
        end else if (act == ACT_HALT) begin
          run_q <= 1'b0;
          exc_q <= EXC_END;
        end else begin
          ip_q <= next_ip;
        end
      end
    end
  end
endmodule

// File: rtl/insn_ptr_seq.sv
module insn_ptr_seq
  import ipu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RESET_IP = 2,
  parameter int STEP     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [OPC_W+ARG_W-1:0]  insn_i,
  input  logic                    tflag_i,
  input  logic [ADDR_W-1:0]       ap_i,
  input  logic                    done_i,
  input  logic                    viol_i,
  output logic [ADDR_W-1:0]       ip_o,
  output logic                    running_o,
  output logic                    malformed_o,
  output logic [EXC_W-1:0]        exit_code_o
);
  localparam int INSN_W = OPC_W + ARG_W;

  logic [OPC_W-1:0]  opc;
  logic [ARG_W-1:0]  arg;
  act_e              act;
  logic              take;
  logic              bad;
  logic [ADDR_W-1:0] next_ip;

  assign opc = insn_i[INSN_W-1:ARG_W];
  assign arg = insn_i[ARG_W-1:0];

  ipu_decode u_dec (
    .opc   (opc),
    .arg   (arg),
    .tflag (tflag_i),
    .act   (act),
    .take  (take),
    .bad   (bad)
  );

  ipu_target #(.ADDR_W(ADDR_W), .STEP(STEP)) u_tgt (
    .ip      (ip_o),
    .ap      (ap_i),
    .arg     (arg),
    .act     (act),
    .take    (take),
    .next_ip (next_ip)
  );

  ipu_state #(.ADDR_W(ADDR_W), .RESET_IP(RESET_IP)) u_st (
    .clk     (clk),
    .rst     (rst),
    .done    (done_i),
    .viol    (viol_i),
    .act     (act),
    .bad     (bad),
    .next_ip (next_ip),
    .ip_q    (ip_o),
    .run_q   (running_o),
    .malf_q  (malformed_o),
    .exc_q   (exit_code_o)
  );
endmodule

// File: rtl/ipu_checker.sv
module ipu_checker
  import ipu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RESET_IP = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [OPC_W+ARG_W-1:0] insn_i,
  input logic                   done_i,
  input logic                   viol_i,
  input logic [ADDR_W-1:0]      ip_o,
  input logic                   running_o,
  input logic                   malformed_o,
  input logic [EXC_W-1:0]       exit_code_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ip_o == ADDR_W'(RESET_IP) && running_o && !malformed_o && exit_code_o == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (running_o && !done_i && !viol_i) |=> (running_o && $stable(ip_o)));

  p_nop_step_r3: assert property (@(posedge clk) disable iff (rst)
    (running_o && done_i && !viol_i && insn_i == 16'h0000)
      |=> (running_o && ip_o == $past(ip_o) + ADDR_W'(2)));

  p_end_halts_r6: assert property (@(posedge clk) disable iff (rst)
    (running_o && done_i && !viol_i && insn_i == 16'hFF00)
      |=> (!running_o && exit_code_o == EXC_END && $stable(ip_o)));

  p_malformed_r7: assert property (@(posedge clk) disable iff (rst)
    (running_o && done_i && !viol_i && insn_i[15:8] == OPC_NOP && insn_i[7:0] != 8'h00)
      |=> (!running_o && malformed_o && exit_code_o == EXC_MALF));

  p_viol_first_r8: assert property (@(posedge clk) disable iff (rst)
    (running_o && viol_i) |=> (!running_o && exit_code_o == EXC_VIOL && $stable(ip_o)));

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !running_o |=> (!running_o && $stable(ip_o) && $stable(exit_code_o) && $stable(malformed_o)));
endmodule

bind insn_ptr_seq ipu_checker #(.ADDR_W(ADDR_W), .RESET_IP(RESET_IP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .insn_i      (insn_i),
  .done_i      (done_i),
  .viol_i      (viol_i),
  .ip_o        (ip_o),
  .running_o   (running_o),
  .malformed_o (malformed_o),
  .exit_code_o (exit_code_o)
);

// File: tb/insn_ptr_seq_bench.sv
module insn_ptr_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] insn = '0;
  logic        tflag = 1'b0;
  logic [15:0] ap = '0;
  logic        done = 1'b0;
  logic        viol = 1'b0;
  logic [15:0] ip_o;
  logic        running_o, malformed_o;
  logic [7:0]  exit_code_o;

  always #10 clk = ~clk;

  insn_ptr_seq u_insn_ptr_seq (
    .clk(clk), .rst(rst), .insn_i(insn), .tflag_i(tflag), .ap_i(ap),
    .done_i(done), .viol_i(viol), .ip_o(ip_o), .running_o(running_o),
    .malformed_o(malformed_o), .exit_code_o(exit_code_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  logic [15:0] m_ip;
  logic        m_run, m_malf;
  logic [7:0]  m_exit;

  function automatic logic [15:0] skip_dist(input int n);
    int v;
    v = (n <= 127) ? 2 * (n + 1) : 2 * (n - 256);
    return v[15:0];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "ip", 32'(ip_o), 32'(m_ip));
    chk(req, "running", 32'(running_o), 32'(m_run));
    chk(req, "exit", 32'(exit_code_o), 32'(m_exit));
    chk(req, "malformed", 32'(malformed_o), 32'(m_malf));
  endtask

  task automatic do_reset();
    rst = 1'b1; done = 1'b0; viol = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    rst = 1'b0;
    m_ip = 16'h0002; m_run = 1'b1; m_exit = 8'h00; m_malf = 1'b0;
    check_all("R1");
  endtask

  task automatic model(input logic [15:0] w, input logic t, input logic [15:0] a,
                       input logic dn, input logic vi);
    logic [7:0] op, ag;
    op = w[15:8]; ag = w[7:0];
    if (!m_run) return;
    if (vi) begin m_run = 0; m_exit = 8'h02; return; end
    if (!dn) return;
    if ((op == 8'h00 || op == 8'hFF || op == 8'hE0 || op == 8'hE1) && ag != 0) begin
      m_run = 0; m_malf = 1; m_exit = 8'h01; return;
    end
    case (op)
      8'hFF: begin m_run = 0; m_exit = 8'h00; end
      8'hE0: m_ip = t ? a : m_ip + 16'd2;
      8'hE1: m_ip = !t ? a : m_ip + 16'd2;
      8'hE2: m_ip = t ? m_ip + 16'd2 + skip_dist(int'(ag)) : m_ip + 16'd2;
      8'hE3: m_ip = !t ? m_ip + 16'd2 + skip_dist(int'(ag)) : m_ip + 16'd2;
      default: m_ip = m_ip + 16'd2;
    endcase
  endtask

  task automatic step(input logic [15:0] w, input logic t, input logic [15:0] a,
                      input logic dn, input logic vi, input string req);
    insn = w; tflag = t; ap = a; done = dn; viol = vi;
    model(w, t, a, dn, vi);
    @(posedge clk); #2;
    check_all(req);
  endtask

  task automatic finish_run();
    if (ended) return;
    ended = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    step(16'hFF00, 1, 16'h0000, 0, 0, "R2");
    step(16'h0000, 0, 16'h0000, 1, 0, "R3");
    step(16'h3A5C, 1, 16'h0000, 1, 0, "R3");
    step(16'hE000, 1, 16'hFFFE, 1, 0, "R4");
    step(16'h0000, 0, 16'h0000, 1, 0, "R3");
    step(16'hE000, 0, 16'h1234, 1, 0, "R4");
    step(16'hE100, 0, 16'h0100, 1, 0, "R4");
    step(16'hE100, 1, 16'h0500, 1, 0, "R4");
    step(16'hE200, 1, 16'h0000, 1, 0, "R5");
    step(16'hE27F, 1, 16'h0000, 1, 0, "R5");
    step(16'hE280, 1, 16'h0000, 1, 0, "R5");
    step(16'hE2FF, 1, 16'h0000, 1, 0, "R5");
    step(16'hE305, 1, 16'h0000, 1, 0, "R5");
    step(16'hE300, 0, 16'h0000, 1, 0, "R5");
    step(16'hFF00, 0, 16'h0000, 1, 0, "R6");
    step(16'h0000, 0, 16'h0000, 1, 0, "R9");
    step(16'hE000, 1, 16'h4444, 1, 1, "R9");
    do_reset();
    step(16'h0001, 0, 16'h0000, 1, 0, "R7");
    do_reset();
    step(16'hE010, 1, 16'h2000, 1, 0, "R7");
    do_reset();
    step(16'hFF00, 0, 16'h0000, 1, 1, "R8");
    do_reset();
    step(16'hE000, 1, 16'h3000, 1, 1, "R8");
    do_reset();
    step(16'hE380, 0, 16'h0000, 1, 0, "R5");
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      logic t, dn, vi;
      logic [15:0] a;
      string tag;
      int r;
      r = $urandom % 100;
      t = 1'($urandom); a = 16'($urandom); dn = 1'b1;
      vi = (($urandom % 64) == 0);
      if (r < 30) begin w = 16'($urandom); tag = "R3"; end
      else if (r < 42) begin w = 16'h0000; tag = "R3"; end
      else if (r < 56) begin w = {7'h70, 1'($urandom), 8'h00}; tag = "R4"; end
      else if (r < 82) begin w = {7'h71, 1'($urandom), 8'($urandom)}; tag = "R5"; end
      else if (r < 84) begin w = 16'hFF00; tag = "R6"; end
      else if (r < 86) begin w = {8'hE0, 8'($urandom) | 8'h01}; tag = "R7"; end
      else begin w = 16'($urandom); dn = 1'b0; tag = "R2"; end
      if (vi) tag = "R8";
      if (!m_run) tag = "R9";
      step(w, t, a, dn, vi, tag);
      if (!m_run && ($urandom % 3) == 0) do_reset();
    end
    finish_run();
  end
endmodule